// File: doc/BRIEF.md
# Shared-Bus Capture and Playback Sequencer

This block paces an 8-bit acquisition path in which an input converter, an external static RAM and an output converter all hang on one data bus. In record mode it starts each conversion itself instead of letting the converter re-trigger from its own end-of-conversion output. It waits a fixed conversion window, then lets the converter drive the bus and strobes the RAM write enable. Last, it releases the bus and asks the address generator for one step. In playback mode the input converter is kept deselected while the RAM drives the bus with output enable low, and the address steps once per playback sample period.

The sequencer is a single state machine with these states: IDLE, REC_START, REC_CONV, REC_READ, REC_WRITE, REC_RELEASE, PLAY_ACCESS and PLAY_STEP. The transitions are:
- IDLE goes to REC_START, or to PLAY_ACCESS, when run is high.
- REC_START always goes to REC_CONV.
- REC_CONV stays for CONV_CYCLES clocks and then goes to REC_READ.
- REC_READ always goes to REC_WRITE, and REC_WRITE always goes to REC_RELEASE.
- REC_RELEASE is a sample boundary.
- PLAY_ACCESS stays for PLAY_CYCLES clocks and then goes to PLAY_STEP.
- PLAY_STEP is a sample boundary.

At either boundary the sequencer samples run and mode_play and picks one of three moves: record again, playback, or IDLE. No other state looks at run or mode_play.

The converter's end-of-conversion input is only observed. If no low level on it is sampled during REC_CONV or REC_READ, the write of that sample is suppressed and a sticky overrun flag is raised. All state is cleared by the asynchronous active-low reset.

Top module: `cap_bus_sequencer`

## Requirements
- R1: After reset, and in IDLE, all outputs are inactive: ram_ce1_n, ram_we_n, ram_oe_n, adc_cs_n, adc_rd_n and adc_wr_n are 1, while ram_ce2, addr_step and overrun are 0.
- R2: A record sample period begins with a single clock in which adc_cs_n=0 and adc_wr_n=0. A conversion is started only in this state and never by adc_eoc_n.
- R3: After the start clock, the sequencer holds adc_cs_n=0 with adc_rd_n=1 and adc_wr_n=1 for exactly CONV_CYCLES clocks.
- R4: Next comes one read clock and then one write clock. In the read clock, adc_cs_n=0, adc_rd_n=0 and ram_we_n=1. In the write clock, adc_rd_n stays 0 and ram_we_n=0. Then follows one release clock in which all converter and RAM controls are inactive and addr_step=1. The record period is therefore CONV_CYCLES+4 clocks.
- R5: Both RAM chip enables (ram_ce1_n=0, ram_ce2=1) are active in the read and write clocks of record and throughout playback. They are inactive in every other state.
- R6: In playback, the sequencer holds adc_cs_n, adc_rd_n, adc_wr_n and ram_we_n at 1 and ram_oe_n at 0 for PLAY_CYCLES+1 clocks. addr_step=1 only in the last of these clocks.
- R7: adc_rd_n=0 and ram_oe_n=0 never occur in the same clock.
- R8: Changes on run or mode_play act only at a sample boundary (REC_RELEASE, PLAY_STEP or IDLE). A sample period already begun always runs to its end.
- R9: If adc_eoc_n is never sampled low in REC_CONV or REC_READ, ram_we_n stays 1 in that write clock and overrun becomes 1 one clock later. overrun then stays 1 until reset.
- R10: adc_eoc_n has no effect on the outputs in IDLE or in playback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 keeps the sequencer cycling; 0 returns it to IDLE at the next boundary |
| mode_play | input | 1 | 1 selects playback, 0 selects record (sampled at boundaries) |
| adc_eoc_n | input | 1 | Converter end-of-conversion, active low |
| ram_ce1_n | output | 1 | RAM chip enable, active low |
| ram_ce2 | output | 1 | RAM chip enable, active high |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rd_n | output | 1 | Converter read (bus drive), active low |
| adc_wr_n | output | 1 | Converter write/start, active low |
| addr_step | output | 1 | One-clock request to advance the address generator |
| overrun | output | 1 | Sticky: a sample was dropped because the conversion was late |

## Verification
The bench builds the block with CONV_CYCLES=2 and PLAY_CYCLES=2. With these values a record period is 6 clocks and a playback period is 3 clocks. A short vector walk can therefore reach every state, both boundary decisions, and a mode or run change placed inside a period. The short conversion window also makes it easy to choose adc_eoc_n patterns that show three cases: a conversion that ends in the window, one that never ends, and an adc_eoc_n low arriving while in playback or IDLE.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REC_START,
        ST_REC_CONV,
        ST_REC_READ,
        ST_REC_WRITE,
        ST_REC_RELEASE,
        ST_PLAY_ACCESS,
        ST_PLAY_STEP
    } cap_state_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic we_n;
        logic oe_n;
        logic cs_n;
        logic rd_n;
        logic wr_n;
        logic step;
    } ctl_bus_t;

    localparam ctl_bus_t CTL_QUIET = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1,
                                       oe_n: 1'b1, cs_n: 1'b1, rd_n: 1'b1,
                                       wr_n: 1'b1, step: 1'b0};

endpackage

// File: rtl/cap_phase_timer.sv
module cap_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/cap_eoc_watch.sv
module cap_eoc_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic watch,
    input  logic judge,
    input  logic eoc_n,
    output logic seen,
    output logic overrun
);

    logic seen_q;
    logic ovr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (clear) begin
            seen_q <= 1'b0;
        end else if (watch && !eoc_n) begin
            seen_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (judge && !seen_q) begin
            ovr_q <= 1'b1;
        end
    end

    assign seen    = seen_q;
    assign overrun = ovr_q;

endmodule

// File: rtl/cap_bus_sequencer.sv
module cap_bus_sequencer
    import cap_pkg::*;
#(
    parameter int CONV_CYCLES = 8,
    parameter int PLAY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic mode_play,
    input  logic adc_eoc_n,
    output logic ram_ce1_n,
    output logic ram_ce2,
    output logic ram_we_n,
    output logic ram_oe_n,
    output logic adc_cs_n,
    output logic adc_rd_n,
    output logic adc_wr_n,
    output logic addr_step,
    output logic overrun
);

    localparam int MAXC = (CONV_CYCLES > PLAY_CYCLES) ? CONV_CYCLES : PLAY_CYCLES;
    localparam int TW   = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [TW-1:0] CONV_LOAD = TW'(CONV_CYCLES - 1);
    localparam logic [TW-1:0] PLAY_LOAD = TW'(PLAY_CYCLES - 1);

    cap_state_e state_q, state_d;
    ctl_bus_t   ctl;
    logic       tmr_load;
    logic [TW-1:0] tmr_val;
    logic       tmr_done;
    logic       eoc_seen;

    // Choice made at every sample boundary
    function automatic cap_state_e boundary_pick(input logic go, input logic play);
        if (!go)       return ST_IDLE;
        else if (play) return ST_PLAY_ACCESS;
        else           return ST_REC_START;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        state_d = boundary_pick(run, mode_play);
            ST_REC_START:   state_d = ST_REC_CONV;
            ST_REC_CONV:    state_d = tmr_done ? ST_REC_READ : ST_REC_CONV;
            ST_REC_READ:    state_d = ST_REC_WRITE;
            ST_REC_WRITE:   state_d = ST_REC_RELEASE;
            ST_REC_RELEASE: state_d = boundary_pick(run, mode_play);
            ST_PLAY_ACCESS: state_d = tmr_done ? ST_PLAY_STEP : ST_PLAY_ACCESS;
            ST_PLAY_STEP:   state_d = boundary_pick(run, mode_play);
            default:        state_d = ST_IDLE;
        endcase
    end

    // Phase timer is armed on entry to a timed state
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = CONV_LOAD;
        if (state_d == ST_REC_CONV && state_q != ST_REC_CONV) begin
            tmr_load = 1'b1;
            tmr_val  = CONV_LOAD;
        end else if (state_d == ST_PLAY_ACCESS && state_q != ST_PLAY_ACCESS) begin
            tmr_load = 1'b1;
            tmr_val  = PLAY_LOAD;
        end
    end

    cap_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    cap_eoc_watch u_eoc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == ST_REC_START),
        .watch   (state_q == ST_REC_CONV || state_q == ST_REC_READ),
        .judge   (state_q == ST_REC_WRITE),
        .eoc_n   (adc_eoc_n),
        .seen    (eoc_seen),
        .overrun (overrun)
    );

    always_comb begin
        ctl = CTL_QUIET;
        unique case (state_q)
            ST_IDLE: ctl = CTL_QUIET;
            ST_REC_START: begin
                ctl.cs_n = 1'b0;
                ctl.wr_n = 1'b0;
            end
            ST_REC_CONV: begin
                ctl.cs_n = 1'b0;
            end
            ST_REC_READ: begin
                ctl.ce1_n = 1'b0;
                ctl.ce2   = 1'b1;
                ctl.cs_n  = 1'b0;
                ctl.rd_n  = 1'b0;
            end
            ST_REC_WRITE: begin
                ctl.ce1_n = 1'b0;
                ctl.ce2   = 1'b1;
                ctl.cs_n  = 1'b0;
                ctl.rd_n  = 1'b0;
                ctl.we_n  = ~eoc_seen;
            end
            ST_REC_RELEASE: begin
                ctl.step = 1'b1;
            end
            ST_PLAY_ACCESS: begin
                ctl.ce1_n = 1'b0;
                ctl.ce2   = 1'b1;
                ctl.oe_n  = 1'b0;
            end
            ST_PLAY_STEP: begin
                ctl.ce1_n = 1'b0;
                ctl.ce2   = 1'b1;
                ctl.oe_n  = 1'b0;
                ctl.step  = 1'b1;
            end
            default: ctl = CTL_QUIET;
        endcase
    end

    assign ram_ce1_n = ctl.ce1_n;
    assign ram_ce2   = ctl.ce2;
    assign ram_we_n  = ctl.we_n;
    assign ram_oe_n  = ctl.oe_n;
    assign adc_cs_n  = ctl.cs_n;
    assign adc_rd_n  = ctl.rd_n;
    assign adc_wr_n  = ctl.wr_n;
    assign addr_step = ctl.step;

endmodule

// File: rtl/cap_bus_sequencer_chk.sv
module cap_bus_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic ram_ce1_n,
    input logic ram_ce2,
    input logic ram_we_n,
    input logic ram_oe_n,
    input logic adc_cs_n,
    input logic adc_rd_n,
    input logic adc_wr_n,
    input logic addr_step,
    input logic overrun
);

    assert_bus_single_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!adc_rd_n && !ram_oe_n));

    assert_start_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_wr_n |=> adc_wr_n);

    assert_start_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_wr_n |-> (!adc_cs_n && ram_we_n && ram_oe_n));

    assert_write_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_ce1_n && ram_ce2 && !adc_rd_n));

    assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> $past(!adc_rd_n && ram_we_n));

    assert_write_then_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |=> (ram_we_n && addr_step && adc_rd_n));

    assert_step_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_step |-> (ram_we_n && adc_rd_n && adc_wr_n));

    assert_play_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> (ram_we_n && adc_cs_n && !ram_ce1_n && ram_ce2));

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind cap_bus_sequencer cap_bus_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ram_ce1_n (ram_ce1_n),
    .ram_ce2   (ram_ce2),
    .ram_we_n  (ram_we_n),
    .ram_oe_n  (ram_oe_n),
    .adc_cs_n  (adc_cs_n),
    .adc_rd_n  (adc_rd_n),
    .adc_wr_n  (adc_wr_n),
    .addr_step (addr_step),
    .overrun   (overrun)
);

// File: tb/cap_bus_sequencer_tb.sv
`timescale 1ns/1ps
module cap_bus_sequencer_tb;

    localparam int CONV = 2;
    localparam int PLAY = 2;

    // Output word: {ce1_n, ce2, we_n, oe_n, cs_n, rd_n, wr_n, step, overrun}
    localparam logic [8:0] O_IDLE  = 9'b101111100;
    localparam logic [8:0] O_START = 9'b101101000;
    localparam logic [8:0] O_CONV  = 9'b101101100;
    localparam logic [8:0] O_READ  = 9'b011100100;
    localparam logic [8:0] O_WRITE = 9'b010100100;
    localparam logic [8:0] O_REL   = 9'b101111110;
    localparam logic [8:0] O_PLAY  = 9'b011011100;
    localparam logic [8:0] O_PSTEP = 9'b011011110;
    localparam logic [8:0] OV      = 9'b000000001;

    localparam int NV = 27;
    // Vector: {run, mode_play, adc_eoc_n, expected outputs after the next edge}
    localparam logic [11:0] VEC [0:NV-1] = '{
        {3'b101, O_START},        // 0  R2
        {3'b101, O_CONV},         // 1  R3
        {3'b100, O_CONV},         // 2  R3 conversion ends
        {3'b100, O_READ},         // 3  R4 R5
        {3'b101, O_WRITE},        // 4  R4
        {3'b101, O_REL},          // 5  R4
        {3'b101, O_START},        // 6  R2
        {3'b101, O_CONV},         // 7  R3
        {3'b101, O_CONV},         // 8  R3
        {3'b101, O_READ},         // 9  R4
        {3'b101, O_READ},         // 10 R9 write suppressed
        {3'b111, O_REL | OV},     // 11 R9 overrun raised
        {3'b111, O_PLAY | OV},    // 12 R6
        {3'b110, O_PLAY | OV},    // 13 R10 eoc ignored
        {3'b110, O_PSTEP | OV},   // 14 R6
        {3'b111, O_PLAY | OV},    // 15 R6
        {3'b101, O_PLAY | OV},    // 16 R8 mode change inside period
        {3'b101, O_PSTEP | OV},   // 17 R8
        {3'b001, O_IDLE | OV},    // 18 R1 R9 sticky
        {3'b000, O_IDLE | OV},    // 19 R10 eoc ignored in idle
        {3'b101, O_START | OV},   // 20 R2
        {3'b111, O_CONV | OV},    // 21 R8
        {3'b110, O_CONV | OV},    // 22 R8
        {3'b111, O_READ | OV},    // 23 R8
        {3'b011, O_WRITE | OV},   // 24 R8 run drop waits
        {3'b011, O_REL | OV},     // 25 R8
        {3'b011, O_IDLE | OV}     // 26 R8
    };

    string vtag [0:NV-1] = '{
        "R2", "R3", "R3", "R4", "R4", "R4", "R2", "R3", "R3", "R4",
        "R9", "R9", "R6", "R10", "R6", "R6", "R8", "R8", "R1", "R10",
        "R2", "R8", "R8", "R8", "R8", "R8", "R8"
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic mode_play = 1'b0;
    logic adc_eoc_n = 1'b1;
    logic ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n;
    logic adc_cs_n, adc_rd_n, adc_wr_n, addr_step, overrun;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cap_bus_sequencer #(.CONV_CYCLES(CONV), .PLAY_CYCLES(PLAY)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .mode_play (mode_play),
        .adc_eoc_n (adc_eoc_n),
        .ram_ce1_n (ram_ce1_n),
        .ram_ce2   (ram_ce2),
        .ram_we_n  (ram_we_n),
        .ram_oe_n  (ram_oe_n),
        .adc_cs_n  (adc_cs_n),
        .adc_rd_n  (adc_rd_n),
        .adc_wr_n  (adc_wr_n),
        .addr_step (addr_step),
        .overrun   (overrun)
    );

    function automatic logic [8:0] outs();
        return {ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n, adc_cs_n,
                adc_rd_n, adc_wr_n, addr_step, overrun};
    endfunction

    task automatic check_word(input string tag, input logic [8:0] exp);
        total++;
        if (outs() !== exp) begin
            bad++;
            $display("FAIL %s: outputs actual=%b expected=%b", tag, outs(), exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Clocks between two addr_step pulses, sampled at falling edges
    task automatic step_period(output int n);
        n = 0;
        while (addr_step !== 1'b1) @(negedge clk);
        @(negedge clk);
        n = 1;
        while (addr_step !== 1'b1 && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int per;
        repeat (3) @(negedge clk);
        check_word("R1 reset", O_IDLE);
        rst_n = 1'b1;
        @(negedge clk);
        check_word("R1 idle after reset", O_IDLE);

        for (int i = 0; i < NV; i++) begin
            {run, mode_play, adc_eoc_n} = VEC[i][11:9];
            @(negedge clk);
            check_word($sformatf("%s vector %0d", vtag[i], i), VEC[i][8:0]);
        end

        // Record period length: CONV+4
        run = 1'b1; mode_play = 1'b0; adc_eoc_n = 1'b0;
        step_period(per);
        check_int("R3 record period", per, CONV + 4);
        step_period(per);
        check_int("R4 record period repeat", per, CONV + 4);

        // Playback period length: PLAY+1
        mode_play = 1'b1;
        step_period(per);
        step_period(per);
        check_int("R6 playback period", per, PLAY + 1);

        // Reset in the middle of a record period clears everything
        mode_play = 1'b0;
        while (adc_wr_n !== 1'b0) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_word("R1 async reset mid record", O_IDLE);
        run = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_word("R1 idle with run low", O_IDLE);

        // eoc toggling in idle starts nothing
        adc_eoc_n = 1'b0;
        @(negedge clk);
        adc_eoc_n = 1'b1;
        @(negedge clk);
        adc_eoc_n = 1'b0;
        @(negedge clk);
        check_word("R2 eoc fall does not start conversion", O_IDLE);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule